// File: doc/BRIEF.md
# Interrupt Enable and Reset-Cause Flag Registers

This block holds two bytes of state for a small controller's interrupt logic. One byte holds the enable bits for four interrupt sources: watchdog interval, oscillator fault, non-maskable pin and flash access violation. The other byte holds the pending flags and the reset-cause flags. Software reads and writes both bytes through a simple byte bus. Hardware events set the flags: a watchdog overflow or key violation, an oscillator fault and an edge on the non-maskable pin.

Three reset sources are kept apart. A power-on reset restores every bit. A reset from the reset pin records its own cause and clears the watchdog flag. A plain power-up clear, such as one caused by the watchdog, returns the enables and the volatile flags to their defaults and keeps the cause flags. This lets software find out, after any restart, why the restart happened.

All resets and writes are synchronous to `clk` and take effect at the next rising edge. Reads are combinational.

Top module: `irq_cause_regs`

## Requirements
- R1: While `por_i` is high at a clock edge, the enable byte becomes 0x00 and the flag byte becomes 0x06 after that edge. This means oscillator-fault flag (bit 1) = 1, power-on flag (bit 2) = 1, all other flags = 0. This applies whatever the other inputs are.
- R2: A clock edge with `pin_rst_i` high and `por_i` low has these effects. The enable byte is cleared. The pin-reset flag (bit 3) is set. The watchdog flag (bit 0) and the NMI flag (bit 4) are cleared. The oscillator-fault flag (bit 1) is set. The power-on flag (bit 2) keeps its value.
- R3: A clock edge with `puc_i` high and `por_i` and `pin_rst_i` low has these effects. The enable byte is cleared, the oscillator-fault flag is set and the NMI flag is cleared. Flag bits 0, 2 and 3 keep their values, except that `wdt_evt_i` in the same cycle sets bit 0.
- R4: A write to byte address 0 (`IE_ADDR`) stores data bits 0, 1, 4 and 5 into the enable byte at the next edge. Enable bits 2, 3, 6 and 7 always read 0.
- R5: A write to byte address 2 (`IFG_ADDR`) stores data bits 0 to 4 into the flag byte at the next edge. Flag bits 5 to 7 always read 0.
- R6: Outside reset, `wdt_evt_i`, `osc_fault_i` and `nmi_edge_i` set flag bits 0, 1 and 4. Each bit stays set until software or a reset clears it.
- R7: When a hardware set event and a software write of 0 to the same flag bit fall in the same cycle, the bit ends up 1.
- R8: A read at any address other than 0 or 2 returns 0x00. A write to any other address changes neither byte.
- R9: `ie_o` and `ifg_o` always show the same values that a read of address 0 and address 2 returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| pin_rst_i | input | 1 | Reset condition from the reset pin, active high |
| puc_i | input | 1 | Other power-up clear source, active high |
| wdt_evt_i | input | 1 | Watchdog overflow or key violation pulse |
| osc_fault_i | input | 1 | Oscillator fault indication |
| nmi_edge_i | input | 1 | Detected edge on the non-maskable pin |
| wr_en_i | input | 1 | Byte write strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| ie_o | output | 8 | Enable byte to the interrupt logic |
| ifg_o | output | 8 | Flag byte to the interrupt logic |

## Verification
The three reset sources are applied with every flag preloaded to 1. This shows which bits each source clears, sets or keeps, and so it separates POR-only bits from PUC bits and from pin-reset bits. All-ones and all-zeros writes to each byte show which bit positions are implemented. Writes to neighbouring addresses must leave both bytes untouched. Single-event pulses, and an event that coincides with a clearing write, separate set-and-hold behaviour from simple level following and check the priority of a hardware set over a software clear.

// File: rtl/irq_cause_regs.sv
module irq_cause_regs #(
  parameter int ADDR_W   = 8,
  parameter int IE_ADDR  = 0,
  parameter int IFG_ADDR = 2
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              pin_rst_i,
  input  logic              puc_i,
  input  logic              wdt_evt_i,
  input  logic              osc_fault_i,
  input  logic              nmi_edge_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [7:0]        ie_o,
  output logic [7:0]        ifg_o
);
  localparam logic [7:0] IE_MASK  = 8'h33;
  localparam logic [7:0] IFG_MASK = 8'h1F;
  localparam logic [7:0] IFG_POR  = 8'h06;

  logic [7:0] ie_q, ifg_q;

  wire sel_ie  = addr_i == ADDR_W'(IE_ADDR);
  wire sel_ifg = addr_i == ADDR_W'(IFG_ADDR);
  wire [7:0] hw_set = {3'b000, nmi_edge_i, 2'b00, osc_fault_i, wdt_evt_i};

  always_ff @(posedge clk) begin
    if (por_i) begin
      ie_q  <= 8'h00;
      ifg_q <= IFG_POR;
    end else if (pin_rst_i) begin
      ie_q  <= 8'h00;
      ifg_q <= {4'b0000, 1'b1, ifg_q[2], 1'b1, 1'b0};
    end else if (puc_i) begin
      ie_q  <= 8'h00;
      ifg_q <= {4'b0000, ifg_q[3], ifg_q[2], 1'b1, ifg_q[0] | wdt_evt_i};
    end else begin
      if (wr_en_i && sel_ie)
        ie_q <= wdata_i & IE_MASK;
      ifg_q <= (((wr_en_i && sel_ifg) ? wdata_i : ifg_q) | hw_set) & IFG_MASK;
    end
  end

  assign ie_o    = ie_q;
  assign ifg_o   = ifg_q;
  assign rdata_o = sel_ie ? ie_q : (sel_ifg ? ifg_q : 8'h00);
endmodule

// File: rtl/irq_cause_regs_chk.sv
module irq_cause_regs_chk #(
  parameter int ADDR_W   = 8,
  parameter int IE_ADDR  = 0,
  parameter int IFG_ADDR = 2
) (
  input logic              clk,
  input logic              por_i,
  input logic              pin_rst_i,
  input logic              puc_i,
  input logic              wdt_evt_i,
  input logic              osc_fault_i,
  input logic              nmi_edge_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        rdata_o,
  input logic [7:0]        ie_o,
  input logic [7:0]        ifg_o
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | por_i;

  wire no_rst = !por_i && !pin_rst_i;

  a_r1_por_state: assert property (@(posedge clk) disable iff (!armed)
    por_i |=> (ie_o == 8'h00 && ifg_o == 8'h06));

  a_r2_pin_cause: assert property (@(posedge clk) disable iff (!armed)
    (pin_rst_i && !por_i) |=> (ie_o == 8'h00 && ifg_o[3] && !ifg_o[0] && ifg_o[1] && !ifg_o[4]));

  a_r3_puc_keeps_cause: assert property (@(posedge clk) disable iff (!armed)
    (puc_i && no_rst) |=> (ifg_o[3:2] == $past(ifg_o[3:2]) && ie_o == 8'h00));

  a_r6_wdt_sets: assert property (@(posedge clk) disable iff (!armed)
    (wdt_evt_i && no_rst) |=> ifg_o[0]);

  a_r7_osc_set_wins: assert property (@(posedge clk) disable iff (!armed)
    (osc_fault_i && !por_i) |=> ifg_o[1]);

  a_r6_nmi_sets: assert property (@(posedge clk) disable iff (!armed)
    (nmi_edge_i && no_rst && !puc_i) |=> ifg_o[4]);

  a_r8_unmapped_read: assert property (@(posedge clk) disable iff (!armed)
    (addr_i != ADDR_W'(IE_ADDR) && addr_i != ADDR_W'(IFG_ADDR)) |-> rdata_o == 8'h00);

  a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!armed)
    (wr_en_i && addr_i != ADDR_W'(IE_ADDR) && !por_i && !pin_rst_i && !puc_i)
      |=> ie_o == $past(ie_o));
endmodule

bind irq_cause_regs irq_cause_regs_chk #(
  .ADDR_W(ADDR_W), .IE_ADDR(IE_ADDR), .IFG_ADDR(IFG_ADDR)
) u_chk (
  .clk(clk), .por_i(por_i), .pin_rst_i(pin_rst_i), .puc_i(puc_i),
  .wdt_evt_i(wdt_evt_i), .osc_fault_i(osc_fault_i), .nmi_edge_i(nmi_edge_i),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .rdata_o(rdata_o), .ie_o(ie_o), .ifg_o(ifg_o)
);

// File: tb/sim_irq_cause_regs.sv
`timescale 1ns/1ps
module sim_irq_cause_regs;
  logic clk = 1'b0;
  logic por = 1'b0, pin = 1'b0, puc = 1'b0;
  logic wdt = 1'b0, osc = 1'b0, nmi = 1'b0;
  logic wr = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata, ie, ifg;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_cause_regs u0 (
    .clk(clk), .por_i(por), .pin_rst_i(pin), .puc_i(puc),
    .wdt_evt_i(wdt), .osc_fault_i(osc), .nmi_edge_i(nmi),
    .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ie_o(ie), .ifg_o(ifg)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic both(input string req, input logic [7:0] e_ie, input logic [7:0] e_ifg);
    logic [7:0] d;
    rd(8'h00, d); chk(req, d, e_ie);
    rd(8'h02, d); chk(req, d, e_ifg);
    chk({req, " R9 ie_o"}, ie, e_ie);
    chk({req, " R9 ifg_o"}, ifg, e_ifg);
  endtask

  task automatic t_por;
    @(negedge clk); por = 1'b1; pin = 1'b1; wdt = 1'b1; nmi = 1'b1;
    @(negedge clk); @(negedge clk);
    por = 1'b0; pin = 1'b0; wdt = 1'b0; nmi = 1'b0;
    both("R1 power-on state", 8'h00, 8'h06);
  endtask

  task automatic t_ie_write;
    wr_byte(8'h00, 8'hFF); both("R4 enable all-ones", 8'h33, 8'h06);
    wr_byte(8'h00, 8'h00); both("R4 enable zero", 8'h00, 8'h06);
  endtask

  task automatic t_ifg_write;
    wr_byte(8'h02, 8'hFF); both("R5 flag all-ones", 8'h00, 8'h1F);
    wr_byte(8'h02, 8'h00); both("R5 flag zero", 8'h00, 8'h00);
  endtask

  task automatic t_events;
    @(negedge clk); wdt = 1'b1; @(negedge clk); wdt = 1'b0;
    both("R6 watchdog event", 8'h00, 8'h01);
    osc = 1'b1; @(negedge clk); osc = 1'b0;
    both("R6 osc fault event", 8'h00, 8'h03);
    nmi = 1'b1; @(negedge clk); nmi = 1'b0;
    @(negedge clk); @(negedge clk);
    both("R6 nmi event held", 8'h00, 8'h13);
    wr_byte(8'h02, 8'h00);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    wr = 1'b1; addr = 8'h02; wdata = 8'h00; osc = 1'b1;
    @(negedge clk);
    wr = 1'b0; osc = 1'b0;
    both("R7 set beats clear", 8'h00, 8'h02);
    wr_byte(8'h02, 8'h00);
  endtask

  task automatic t_other_addr;
    logic [7:0] d;
    wr_byte(8'h00, 8'h11);
    wr_byte(8'h02, 8'h05);
    wr_byte(8'h01, 8'hFF);
    wr_byte(8'h03, 8'hFF);
    wr_byte(8'h80, 8'hFF);
    both("R8 other writes ignored", 8'h11, 8'h05);
    rd(8'h01, d); chk("R8 read addr 1", d, 8'h00);
    rd(8'h03, d); chk("R8 read addr 3", d, 8'h00);
    rd(8'hFE, d); chk("R8 read addr FE", d, 8'h00);
  endtask

  task automatic t_pin;
    wr_byte(8'h00, 8'h33);
    wr_byte(8'h02, 8'h1F);
    @(negedge clk); pin = 1'b1; @(negedge clk); pin = 1'b0;
    both("R2 pin reset", 8'h00, 8'h0E);
  endtask

  task automatic t_puc;
    wr_byte(8'h00, 8'h33);
    wr_byte(8'h02, 8'h1D);
    @(negedge clk); puc = 1'b1; @(negedge clk); puc = 1'b0;
    both("R3 puc keeps cause flags", 8'h00, 8'h0F);
    wr_byte(8'h02, 8'h00);
    @(negedge clk); puc = 1'b1; wdt = 1'b1; @(negedge clk); puc = 1'b0; wdt = 1'b0;
    both("R3 puc with watchdog", 8'h00, 8'h03);
    @(negedge clk); puc = 1'b1; nmi = 1'b1; @(negedge clk); puc = 1'b0; nmi = 1'b0;
    both("R3 puc clears nmi", 8'h00, 8'h03);
  endtask

  initial begin
    t_por;
    t_ie_write;
    t_ifg_write;
    t_events;
    t_set_wins;
    t_other_addr;
    t_pin;
    t_puc;
    t_por;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule